// File: doc/BRIEF.md
# Frame DMA Channel Controller

This block is the register front end and sequencer for a single bus-master DMA channel that moves one frame of 32-bit words. Software programs a word-aligned base address and a word count. It then writes a control word that selects the direction, chooses whether an interrupt is wanted, and sets the go bit. The channel then presents one request per word on a valid/ready memory port. The address steps by four after every accepted word, until the count is used up or the responder signals a fault.

The same control write that arms a new transfer also clears the interrupt from the previous one. Software can therefore acknowledge and re-arm with one access, or only acknowledge by leaving the go bit clear. A fault ends the transfer early, sets a sticky error flag, and still raises the interrupt when one was requested. A zero count finishes without any bus request.

Top module: `dma_frame_channel`

## Requirements
- R1: The base-address register (index 0) keeps bits 31:2 of a write. Bits 1:0 always read back as zero, whatever was written to them.
- R2: The count register (index 1) keeps bits 20:0 of a write. Bits 31:21 read back as zero. Index 3 reads zero.
- R3: The control register (index 2) reads back as bit 0 error flag, bit 1 interrupt request, bit 2 busy (the go bit), and bit 3 direction (1 = device to host, 0 = host to device). All other bits read zero, and after reset every register reads zero.
- R4: A control write with bit 2 set, made while idle with a nonzero count, makes `mem_valid` high from the next cycle. The channel then issues exactly count requests at base, base+4, base+8 and so on, with `mem_to_host` equal to the direction bit.
- R5: While `mem_valid` is high and `mem_ready` is low, the request address and direction hold steady and `mem_valid` stays high.
- R6: The busy bit (control bit 2) clears by itself in the cycle after the last word is accepted.
- R7: `irq` rises only when a transfer ends, and only if its interrupt bit was set. It stays high until the next control write and is never high while a request is outstanding.
- R8: Every accepted control write clears a pending `irq`. Writing 0xB only acknowledges: no transfer starts, and the control register then reads 0xA. Writing 0xF acknowledges and starts a device-to-host transfer that interrupts on completion.
- R9: While busy, all register writes are ignored, including a second start and any base or count change.
- R10: A `mem_err` on an accepted word sets the error flag, ends the transfer after that word, and raises `irq` if requested. A control write with bit 0 set clears the error flag.
- R11: Starting with a count of zero finishes at once. No request is issued, and `irq` is high in the next cycle if bit 1 of that write was set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_idx | input | 2 | Register index for writes (0 base, 1 count, 2 control) |
| cfg_wdata | input | 32 | Register write data |
| cfg_ridx | input | 2 | Register index for reads |
| cfg_rdata | output | 32 | Read data for `cfg_ridx` |
| mem_valid | output | 1 | Word request valid |
| mem_ready | input | 1 | Responder accepts the current request |
| mem_addr | output | 32 | Byte address of the current word |
| mem_to_host | output | 1 | Direction of the current word (1 = device to host) |
| mem_err | input | 1 | Fault response, qualified by `mem_valid` and `mem_ready` |
| irq | output | 1 | Completion interrupt, held until the next control write |

## Verification
The hardest situation to reach from the ports is a fault on a word in the middle of a transfer. It has to land on one specific accepted word, while the responder may be stalling and the count has not yet run out. The bench counts accepted words itself and raises `mem_err` exactly while the chosen word is on the bus, so the early stop, the error flag and the interrupt all fall on a known cycle. A second hard case is a start or base write that arrives while a transfer is in flight. The bench issues these a few cycles after a start and later reads the registers to show that they left no trace.

// File: rtl/dma_frame_pkg.sv
package dma_frame_pkg;

   typedef enum logic [1:0] {
      RIDX_BASE  = 2'd0,
      RIDX_COUNT = 2'd1,
      RIDX_CTRL  = 2'd2,
      RIDX_SPARE = 2'd3
   } ridx_e;

   // control word bit positions (software decodes these)
   localparam int unsigned CB_ERR = 0;
   localparam int unsigned CB_IEN = 1;
   localparam int unsigned CB_GO  = 2;
   localparam int unsigned CB_DIR = 3;
   localparam int unsigned CB_NUM = 4;

   typedef struct packed {
      logic dir;
      logic go;
      logic ien;
      logic clr_err;
   } ctl_cmd_t;

endpackage

// File: rtl/dma_frame_regs.sv
module dma_frame_regs
   import dma_frame_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned LEN_W  = 21
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [1:0]        idx,
   input  logic [DATA_W-1:0] wdata,
   input  logic              busy,
   output logic [ADDR_W-3:0] base_word,
   output logic [LEN_W-1:0]  count,
   output logic              ien,
   output logic              dir,
   output logic              ctl_stb,
   output ctl_cmd_t          cmd
);

   logic  wr_ok;
   ridx_e widx;

   assign widx  = ridx_e'(idx);
   assign wr_ok = we && !busy;

   assign cmd.dir     = wdata[CB_DIR];
   assign cmd.go      = wdata[CB_GO];
   assign cmd.ien     = wdata[CB_IEN];
   assign cmd.clr_err = wdata[CB_ERR];

   assign ctl_stb = wr_ok && (widx == RIDX_CTRL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_word <= '0;
         count     <= '0;
         ien       <= 1'b0;
         dir       <= 1'b0;
      end else if (wr_ok) begin
         case (widx)
            RIDX_BASE:  base_word <= wdata[ADDR_W-1:2];
            RIDX_COUNT: count     <= wdata[LEN_W-1:0];
            RIDX_CTRL: begin
               ien <= cmd.ien;
               dir <= cmd.dir;
            end
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/dma_frame_seq.sv
module dma_frame_seq #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned LEN_W  = 21
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-3:0] base_word,
   input  logic [LEN_W-1:0]  count,
   input  logic              ready,
   input  logic              fault_in,
   output logic              busy,
   output logic [ADDR_W-3:0] cur_word,
   output logic              done,
   output logic              fault
);

   logic [LEN_W-1:0] left;
   logic             hs;
   logic             last;
   logic             empty;

   assign hs    = busy && ready;
   assign last  = (left == LEN_W'(1));
   assign empty = (count == '0);
   assign fault = hs && fault_in;
   assign done  = (start && empty) || (hs && (last || fault_in));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         cur_word <= '0;
         left     <= '0;
      end else if (start) begin
         busy     <= !empty;
         cur_word <= base_word;
         left     <= count;
      end else if (hs) begin
         if (last || fault_in) begin
            busy <= 1'b0;
         end else begin
            cur_word <= cur_word + 1'b1;
            left     <= left - 1'b1;
         end
      end
   end

endmodule

// File: rtl/dma_frame_status.sv
module dma_frame_status (
   input  logic clk,
   input  logic rst_n,
   input  logic ctl_stb,
   input  logic ien_wr,
   input  logic clr_err,
   input  logic ien,
   input  logic done,
   input  logic fault,
   output logic err,
   output logic irq
);

   logic ien_now;

   // a zero-length start ends in the same cycle as its own write
   assign ien_now = ctl_stb ? ien_wr : ien;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         err <= 1'b0;
         irq <= 1'b0;
      end else begin
         if (fault)
            err <= 1'b1;
         else if (ctl_stb && clr_err)
            err <= 1'b0;

         if (done)
            irq <= ien_now;
         else if (ctl_stb)
            irq <= 1'b0;
      end
   end

endmodule

// File: rtl/dma_frame_channel.sv
module dma_frame_channel
   import dma_frame_pkg::*;
#(
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned ADDR_W   = 32,
   parameter int unsigned LEN_W    = 21,
   parameter bit          READ_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [1:0]        cfg_idx,
   input  logic [DATA_W-1:0] cfg_wdata,
   input  logic [1:0]        cfg_ridx,
   output logic [DATA_W-1:0] cfg_rdata,
   output logic              mem_valid,
   input  logic              mem_ready,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_to_host,
   input  logic              mem_err,
   output logic              irq
);

   localparam int unsigned WORD_W = ADDR_W - 2;

   if (ADDR_W < 3 || ADDR_W > DATA_W) begin : g_bad_addr_w
      $error("ADDR_W must lie between 3 and DATA_W");
   end
   if (LEN_W < 1 || LEN_W > DATA_W) begin : g_bad_len_w
      $error("LEN_W must lie between 1 and DATA_W");
   end
   if (DATA_W < CB_NUM) begin : g_bad_data_w
      $error("DATA_W too narrow for the control word");
   end

   logic [WORD_W-1:0] base_word;
   logic [WORD_W-1:0] cur_word;
   logic [LEN_W-1:0]  count;
   logic              ien;
   logic              dir;
   logic              ctl_stb;
   ctl_cmd_t          cmd;
   logic              busy;
   logic              done;
   logic              fault;
   logic              err_flag;
   logic [DATA_W-1:0] rd_next;

   dma_frame_regs #(
      .DATA_W (DATA_W),
      .ADDR_W (ADDR_W),
      .LEN_W  (LEN_W)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .we        (cfg_we),
      .idx       (cfg_idx),
      .wdata     (cfg_wdata),
      .busy      (busy),
      .base_word (base_word),
      .count     (count),
      .ien       (ien),
      .dir       (dir),
      .ctl_stb   (ctl_stb),
      .cmd       (cmd)
   );

   dma_frame_seq #(
      .ADDR_W (ADDR_W),
      .LEN_W  (LEN_W)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (ctl_stb && cmd.go),
      .base_word (base_word),
      .count     (count),
      .ready     (mem_ready),
      .fault_in  (mem_err),
      .busy      (busy),
      .cur_word  (cur_word),
      .done      (done),
      .fault     (fault)
   );

   dma_frame_status u_status (
      .clk     (clk),
      .rst_n   (rst_n),
      .ctl_stb (ctl_stb),
      .ien_wr  (cmd.ien),
      .clr_err (cmd.clr_err),
      .ien     (ien),
      .done    (done),
      .fault   (fault),
      .err     (err_flag),
      .irq     (irq)
   );

   assign mem_valid   = busy;
   assign mem_addr    = {cur_word, 2'b00};
   assign mem_to_host = dir;

   always_comb begin
      rd_next = '0;
      case (ridx_e'(cfg_ridx))
         RIDX_BASE:  rd_next = DATA_W'({base_word, 2'b00});
         RIDX_COUNT: rd_next = DATA_W'(count);
         RIDX_CTRL:  rd_next = DATA_W'({dir, busy, ien, err_flag});
         default:    rd_next = '0;
      endcase
   end

   if (READ_REG) begin : g_rd_flop
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) cfg_rdata <= '0;
         else        cfg_rdata <= rd_next;
      end
   end else begin : g_rd_comb
      assign cfg_rdata = rd_next;
   end

endmodule

// File: rtl/dma_frame_channel_chk.sv
module dma_frame_channel_chk #(
   parameter int unsigned ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_we,
   input logic              mem_valid,
   input logic              mem_ready,
   input logic              mem_err,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              mem_to_host,
   input logic              irq,
   input logic              err_flag
);

   p_hold_request_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_to_host)))
      else $error("R5 request changed while stalled");

   p_end_after_accept_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mem_valid) |-> $past(mem_ready))
      else $error("R6 request dropped without acceptance");

   p_irq_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> ($past(cfg_we) || $past(mem_valid && mem_ready)))
      else $error("R7 interrupt without an ending event");

   p_quiet_while_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
      mem_valid |-> !irq)
      else $error("R7 interrupt high during a transfer");

   p_err_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_flag) |-> $past(mem_valid && mem_ready && mem_err))
      else $error("R10 error flag set without a fault");

endmodule

bind dma_frame_channel dma_frame_channel_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cfg_we      (cfg_we),
   .mem_valid   (mem_valid),
   .mem_ready   (mem_ready),
   .mem_err     (mem_err),
   .mem_addr    (mem_addr),
   .mem_to_host (mem_to_host),
   .irq         (irq),
   .err_flag    (err_flag)
);

// File: tb/dma_frame_channel_test.sv
`timescale 1ns/1ps
module dma_frame_channel_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_idx = 2'd0;
   logic [31:0] cfg_wdata = 32'd0;
   logic [1:0]  cfg_ridx = 2'd2;
   logic [31:0] cfg_rdata;
   logic        mem_valid;
   logic        mem_ready = 1'b1;
   logic [31:0] mem_addr;
   logic        mem_to_host;
   logic        mem_err = 1'b0;
   logic        irq;

   int vectors = 0;
   int misses  = 0;
   int cycles  = 0;
   int hs_seen = 0;
   int err_target = -1;
   bit rdy_rand = 1'b0;

   // behavioural reference state
   logic [31:0] m_base = 0, m_cur = 0;
   int          m_len = 0, m_rem = 0;
   bit          m_busy = 0, m_irq = 0, m_err = 0, m_ien = 0, m_dir = 0;

   always #2.5 clk = ~clk;

   dma_frame_channel uut (
      .clk (clk), .rst_n (rst_n), .cfg_we (cfg_we), .cfg_idx (cfg_idx),
      .cfg_wdata (cfg_wdata), .cfg_ridx (cfg_ridx), .cfg_rdata (cfg_rdata),
      .mem_valid (mem_valid), .mem_ready (mem_ready), .mem_addr (mem_addr),
      .mem_to_host (mem_to_host), .mem_err (mem_err), .irq (irq)
   );

   task automatic cmp(input string req, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         misses++;
         $display("FAIL %s at %0t: actual %h expected %h", req, $time, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_read(input logic [1:0] r);
      case (r)
         2'd0:    return m_base;
         2'd1:    return 32'(m_len);
         2'd2:    return {28'd0, m_dir, m_busy, m_ien, m_err};
         default: return 32'd0;
      endcase
   endfunction

   // reference model update and per-cycle comparison
   always @(posedge clk) begin
      cycles++;
      if (!rst_n) begin
         m_base = 0; m_cur = 0; m_len = 0; m_rem = 0;
         m_busy = 0; m_irq = 0; m_err = 0; m_ien = 0; m_dir = 0;
      end else if (m_busy) begin
         if (mem_ready) begin
            hs_seen++;
            if (mem_err) begin
               m_err = 1; m_busy = 0; m_irq = m_ien;
            end else begin
               m_cur = m_cur + 32'd4;
               m_rem--;
               if (m_rem == 0) begin
                  m_busy = 0; m_irq = m_ien;
               end
            end
         end
      end else if (cfg_we) begin
         case (cfg_idx)
            2'd0: m_base = cfg_wdata & 32'hFFFF_FFFC;
            2'd1: m_len  = int'(cfg_wdata & 32'h001F_FFFF);
            2'd2: begin
               m_ien = cfg_wdata[1];
               m_dir = cfg_wdata[3];
               if (cfg_wdata[0]) m_err = 0;
               m_irq = 0;
               if (cfg_wdata[2]) begin
                  if (m_len == 0) m_irq = cfg_wdata[1];
                  else begin
                     m_busy = 1; m_cur = m_base; m_rem = m_len;
                  end
               end
            end
            default: ;
         endcase
      end
      #1.5;
      if (rst_n) begin
         cmp("R4 valid", 32'(mem_valid), 32'(m_busy));
         if (m_busy) begin
            cmp("R5 addr", mem_addr, m_cur);
            cmp("R4 dir", 32'(mem_to_host), 32'(m_dir));
         end
         cmp("R7 irq", 32'(irq), 32'(m_irq));
         case (cfg_ridx)
            2'd0:    cmp("R1 read", cfg_rdata, exp_read(cfg_ridx));
            2'd1:    cmp("R2 read", cfg_rdata, exp_read(cfg_ridx));
            default: cmp("R3 read", cfg_rdata, exp_read(cfg_ridx));
         endcase
      end
      if (cycles > 150000) begin
         misses++;
         $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
         $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
         $finish;
      end
   end

   // responder
   always @(negedge clk) begin
      mem_ready = rdy_rand ? 1'($urandom % 2) : 1'b1;
      mem_err   = (err_target >= 0) && (hs_seen == err_target);
   end

   task automatic wr(input logic [1:0] i, input logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_idx = i; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic rd(input logic [1:0] i, input logic [31:0] exp, input string req);
      @(negedge clk);
      cfg_ridx = i;
      #1;
      cmp(req, cfg_rdata, exp);
   endtask

   task automatic wait_idle();
      for (int n = 0; n < 5000 && mem_valid; n++) @(negedge clk);
      @(negedge clk);
   endtask

   int s0;

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // reset state
      rd(2'd0, 32'd0, "R3 reset base");
      rd(2'd2, 32'd0, "R3 reset ctrl");
      cmp("R7 reset irq", 32'(irq), 32'd0);

      // R1 low address bits dropped
      wr(2'd0, 32'h1234_5677);
      rd(2'd0, 32'h1234_5674, "R1 align");
      // R2 count field width
      wr(2'd1, 32'hFFFF_FFFF);
      rd(2'd1, 32'h001F_FFFF, "R2 width");
      rd(2'd3, 32'd0, "R2 spare");

      // R4/R6/R7 basic transfer with 0xF
      wr(2'd0, 32'h0000_0100);
      wr(2'd1, 32'd5);
      cfg_ridx = 2'd2;
      s0 = hs_seen;
      wr(2'd2, 32'hF);
      wait_idle();
      cmp("R4 beats", 32'(hs_seen - s0), 32'd5);
      rd(2'd2, 32'hA, "R6 go cleared");
      cmp("R7 irq set", 32'(irq), 32'd1);

      // R8 acknowledge only
      wr(2'd2, 32'hB);
      cmp("R8 irq cleared", 32'(irq), 32'd0);
      cmp("R8 no start", 32'(mem_valid), 32'd0);
      rd(2'd2, 32'hA, "R8 ctrl");

      // R5/R7 stalled transfer without interrupt, host to device
      rdy_rand = 1'b1;
      wr(2'd1, 32'd20);
      cfg_ridx = 2'd2;
      s0 = hs_seen;
      wr(2'd2, 32'h4);
      wait_idle();
      cmp("R5 beats", 32'(hs_seen - s0), 32'd20);
      cmp("R7 no irq", 32'(irq), 32'd0);
      rdy_rand = 1'b0;

      // R9 writes during a transfer ignored
      wr(2'd1, 32'd10);
      cfg_ridx = 2'd2;
      wr(2'd2, 32'h6);
      @(negedge clk);
      wr(2'd0, 32'h0000_9000);
      wr(2'd2, 32'hF);
      wait_idle();
      rd(2'd0, 32'h0000_0100, "R9 base kept");
      rd(2'd2, 32'h2, "R9 ctrl kept");
      cmp("R9 irq", 32'(irq), 32'd1);
      cmp("R9 no restart", 32'(mem_valid), 32'd0);

      // R10 fault on the fourth word
      wr(2'd1, 32'd8);
      cfg_ridx = 2'd2;
      s0 = hs_seen;
      err_target = s0 + 3;
      wr(2'd2, 32'h6);
      wait_idle();
      err_target = -1;
      cmp("R10 beats", 32'(hs_seen - s0), 32'd4);
      rd(2'd2, 32'h3, "R10 err set");
      cmp("R10 irq", 32'(irq), 32'd1);
      wr(2'd2, 32'h1);
      rd(2'd2, 32'h0, "R10 err cleared");

      // R11 zero count
      wr(2'd1, 32'd0);
      s0 = hs_seen;
      wr(2'd2, 32'hE);
      cmp("R11 irq", 32'(irq), 32'd1);
      cmp("R11 no request", 32'(mem_valid), 32'd0);
      rd(2'd2, 32'hA, "R11 ctrl");
      cmp("R11 beats", 32'(hs_seen - s0), 32'd0);

      // long transfer across an address wrap with random stalls
      rdy_rand = 1'b1;
      wr(2'd0, 32'hFFFF_FF00);
      wr(2'd1, 32'd300);
      cfg_ridx = 2'd2;
      s0 = hs_seen;
      wr(2'd2, 32'hF);
      wait_idle();
      rdy_rand = 1'b0;
      cmp("R4 long beats", 32'(hs_seen - s0), 32'd300);
      cmp("R7 long irq", 32'(irq), 32'd1);

      repeat (4) @(negedge clk);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
   end

endmodule